// File: doc/BRIEF.md
# Multicycle CPU Control Sequencer

This block is the control state machine of a small accumulator-style CPU. The program is written into the instruction memory while the run input is low. Raising the run input starts execution. For each instruction the sequencer takes three cycles: a fetch cycle in which the instruction memory is read at the program counter, a cycle in which the instruction register is loaded, and an execute cycle. In the execute cycle the function field held in the instruction register is decoded into register loads, data-memory accesses, ALU controls and a single program-counter advance pulse.

The function field is three bits wide:
- 000 loads register A or B, selected by a one-bit register select.
- 010 runs the ALU and loads register C.
- 001 writes the data memory.
- 011 reads the data memory.
- 111 ends the program.

The codes 100, 101 and 110 are treated as no-ops. Once the exit code has executed, the sequencer parks in a halt state that only reset leaves. Every control output is decoded from the registered state together with the instruction-register fields. Each output therefore lasts exactly one execute or load cycle.

Top module: `cpu_ctl`

## Requirements
- R1: After a synchronous reset the sequencer is idle: every load, memory enable and ALU output is 0.
- R2: While `run_en` is 0, no load (`ld_ir`, `ld_pc`, `ld_a`, `ld_b`, `ld_c`) and no memory enable (`dm_we`, `dm_re`) is asserted.
- R3: `addr_sel` equals `run_en` in every cycle: 1 selects the program counter and 0 selects the external load address.
- R4: With `run_en` at 1, idle moves to fetch on the next clock. Fetch asserts nothing. The following cycle asserts only `ld_ir`, and the cycle after that is the execute cycle.
- R5: `ld_pc` is high for exactly one cycle, the execute cycle, of every instruction except exit.
- R6: Function 000 asserts `ld_a` when `reg_sel` is 0 and `ld_b` when `reg_sel` is 1, never both.
- R7: Function 010 asserts `ld_c` and drives `alu_op`/`alu_mode` from `alu_op_in`/`alu_mode_in`. In every other cycle `alu_op` and `alu_mode` are 0.
- R8: Function 001 asserts `dm_we` and function 011 asserts `dm_re`, each for the execute cycle only.
- R9: Function 111 asserts no load, including no `ld_pc`, and enters halt. After that no `ld_ir` or other load occurs until reset, whatever `run_en` does.
- R10: Functions 100, 101 and 110 assert only `ld_pc` in their execute cycle.
- R11: `run_en` falling to 0 before halt returns the sequencer to idle. Raising it again restarts at a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; 0 while the program is being loaded |
| func | input | 3 | Function field from the instruction register |
| alu_op_in | input | OP_W | ALU opcode field from the instruction register |
| alu_mode_in | input | 1 | ALU mode bit from the instruction register |
| reg_sel | input | 1 | Register select bit (0 = A, 1 = B) |
| ld_ir | output | 1 | Instruction register load |
| ld_pc | output | 1 | Program counter advance pulse |
| ld_a | output | 1 | Register A load |
| ld_b | output | 1 | Register B load |
| ld_c | output | 1 | Register C load |
| dm_we | output | 1 | Data memory write enable |
| dm_re | output | 1 | Data memory read enable |
| addr_sel | output | 1 | Instruction address select (1 = program counter) |
| alu_op | output | OP_W | ALU opcode to the datapath |
| alu_mode | output | 1 | ALU mode to the datapath |

## Verification
The assertions assume that the instruction-register fields change only at the clock edge that closes a load cycle. They also assume `run_en` is a synchronous level that may change in any cycle. In the bench, a behavioural instruction register and program counter are updated only from the sequencer's own `ld_ir` and `ld_pc` pulses, so the fields stay stable through each execute cycle. The run input is changed only at falling clock edges, which covers mid-program aborts and toggles after halt.

// File: rtl/cpu_ctl_pkg.sv
package cpu_ctl_pkg;
  localparam int FN_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LOAD  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_HALT  = 3'd4
  } ctl_state_t;

  localparam logic [FN_W-1:0] FN_LDREG = 3'b000;
  localparam logic [FN_W-1:0] FN_STORE = 3'b001;
  localparam logic [FN_W-1:0] FN_ALU   = 3'b010;
  localparam logic [FN_W-1:0] FN_READ  = 3'b011;
  localparam logic [FN_W-1:0] FN_EXIT  = 3'b111;
endpackage

// File: rtl/cpu_ctl_seq.sv
module cpu_ctl_seq
  import cpu_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic [FN_W-1:0] func,
  output ctl_state_t      state
);
  ctl_state_t state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  state_d = run_en ? ST_FETCH : ST_IDLE;
      ST_FETCH: state_d = run_en ? ST_LOAD  : ST_IDLE;
      ST_LOAD:  state_d = run_en ? ST_EXEC  : ST_IDLE;
      ST_EXEC: begin
        if (!run_en)              state_d = ST_IDLE;
        else if (func == FN_EXIT) state_d = ST_HALT;
        else                      state_d = ST_FETCH;
      end
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_d;
  end

  // R9: halt is terminal until reset
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |=> (state == ST_HALT));
  // R4: a fetch under run is followed by the instruction-register load cycle
  a_r4_fetch_then_load: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && run_en) |=> (state == ST_LOAD));
  // R11: dropping run outside halt returns to idle
  a_r11_drop_to_idle: assert property (@(posedge clk) disable iff (rst)
    (!run_en && state != ST_HALT) |=> (state == ST_IDLE));
endmodule

// File: rtl/cpu_ctl_dec.sv
module cpu_ctl_dec
  import cpu_ctl_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  ctl_state_t      state,
  input  logic            run_en,
  input  logic [FN_W-1:0] func,
  input  logic [OP_W-1:0] alu_op_in,
  input  logic            alu_mode_in,
  input  logic            reg_sel,
  output logic            ld_ir,
  output logic            ld_pc,
  output logic            ld_a,
  output logic            ld_b,
  output logic            ld_c,
  output logic            dm_we,
  output logic            dm_re,
  output logic            addr_sel,
  output logic [OP_W-1:0] alu_op,
  output logic            alu_mode
);
  always_comb begin
    ld_ir    = 1'b0;
    ld_pc    = 1'b0;
    ld_a     = 1'b0;
    ld_b     = 1'b0;
    ld_c     = 1'b0;
    dm_we    = 1'b0;
    dm_re    = 1'b0;
    alu_op   = '0;
    alu_mode = 1'b0;
    addr_sel = run_en;
    if (run_en) begin
      if (state == ST_LOAD) ld_ir = 1'b1;
      if (state == ST_EXEC) begin
        ld_pc = (func != FN_EXIT);
        case (func)
          FN_LDREG: begin
            ld_a = !reg_sel;
            ld_b = reg_sel;
          end
          FN_ALU: begin
            ld_c     = 1'b1;
            alu_op   = alu_op_in;
            alu_mode = alu_mode_in;
          end
          FN_STORE: dm_we = 1'b1;
          FN_READ:  dm_re = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R2: no loads or memory access without run
  a_r2_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !run_en |-> !(ld_ir || ld_pc || ld_a || ld_b || ld_c || dm_we || dm_re));
  // R5: the program-counter pulse never lasts two cycles
  a_r5_pc_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ld_pc |=> !ld_pc);
  // R6: A and B are never loaded together
  a_r6_ab_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ld_a && ld_b));
  // R7: the ALU controls are quiet outside a C load
  a_r7_alu_quiet: assert property (@(posedge clk) disable iff (rst)
    !ld_c |-> (alu_op == '0 && !alu_mode));
  // R8: a data-memory read and write never coincide
  a_r8_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dm_we && dm_re));
  // R4: the instruction register load is always followed by an execute cycle or an abort
  a_r4_load_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> !ld_ir);
endmodule

// File: rtl/cpu_ctl.sv
module cpu_ctl
  import cpu_ctl_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic [2:0]      func,
  input  logic [OP_W-1:0] alu_op_in,
  input  logic            alu_mode_in,
  input  logic            reg_sel,
  output logic            ld_ir,
  output logic            ld_pc,
  output logic            ld_a,
  output logic            ld_b,
  output logic            ld_c,
  output logic            dm_we,
  output logic            dm_re,
  output logic            addr_sel,
  output logic [OP_W-1:0] alu_op,
  output logic            alu_mode
);
  ctl_state_t state;

  cpu_ctl_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .func   (func),
    .state  (state)
  );

  cpu_ctl_dec #(.OP_W(OP_W)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .run_en      (run_en),
    .func        (func),
    .alu_op_in   (alu_op_in),
    .alu_mode_in (alu_mode_in),
    .reg_sel     (reg_sel),
    .ld_ir       (ld_ir),
    .ld_pc       (ld_pc),
    .ld_a        (ld_a),
    .ld_b        (ld_b),
    .ld_c        (ld_c),
    .dm_we       (dm_we),
    .dm_re       (dm_re),
    .addr_sel    (addr_sel),
    .alu_op      (alu_op),
    .alu_mode    (alu_mode)
  );
endmodule

// File: tb/tb_cpu_ctl.sv
module tb_cpu_ctl;
  localparam int OP_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [7:0] ir;
  logic [3:0] pc;
  logic ld_ir, ld_pc, ld_a, ld_b, ld_c, dm_we, dm_re, addr_sel, alu_mode;
  logic [OP_W-1:0] alu_op;

  always #10 clk = ~clk;

  cpu_ctl #(.OP_W(OP_W)) dut (
    .clk(clk), .rst(rst), .run_en(run_en),
    .func(ir[7:5]), .alu_op_in(ir[4:2]), .alu_mode_in(ir[1]), .reg_sel(ir[0]),
    .ld_ir(ld_ir), .ld_pc(ld_pc), .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c),
    .dm_we(dm_we), .dm_re(dm_re), .addr_sel(addr_sel),
    .alu_op(alu_op), .alu_mode(alu_mode)
  );

  // program: {func[2:0], op[2:0], mode, sel}
  function automatic logic [7:0] prog(input logic [3:0] a);
    case (a)
      4'd0:  prog = 8'b000_000_0_0;
      4'd1:  prog = 8'b000_000_0_1;
      4'd2:  prog = 8'b010_101_1_0;
      4'd3:  prog = 8'b001_011_0_1;
      4'd4:  prog = 8'b100_111_1_1;
      4'd5:  prog = 8'b011_000_0_0;
      4'd6:  prog = 8'b101_010_1_0;
      4'd7:  prog = 8'b010_010_0_1;
      4'd8:  prog = 8'b110_001_1_1;
      4'd9:  prog = 8'b000_110_1_1;
      4'd10: prog = 8'b001_000_0_0;
      4'd11: prog = 8'b111_000_0_0;
      4'd12: prog = 8'b011_000_0_0;
      default: prog = 8'h00;
    endcase
  endfunction

  // reference model: 0 idle, 1 fetch, 2 load, 3 execute, 4 halt
  int ms;
  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit just_reset = 0;
  bit en_fell = 0;
  bit prev_en = 0;
  logic s_ld_ir = 0, s_ld_pc = 0;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0;
      just_reset = 1;
    end else begin
      case (ms)
        0: ms = run_en ? 1 : 0;
        1: ms = run_en ? 2 : 0;
        2: ms = run_en ? 3 : 0;
        3: ms = !run_en ? 0 : (ir[7:5] == 3'b111 ? 4 : 1);
        default: ms = 4;
      endcase
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      ir <= 8'h00;
      pc <= 4'd0;
    end else begin
      if (s_ld_ir) ir <= prog(pc);
      if (s_ld_pc) pc <= pc + 4'd1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (model state %0d, func %b)", tag, act, exp, ms, ir[7:5]);
    end
  endtask

  always begin
    @(negedge clk);
    #5;
    if (!rst) begin
      logic e_ir, e_pc, e_a, e_b, e_c, e_we, e_re, e_mode;
      logic [OP_W-1:0] e_op;
      string tag;
      e_ir = 0; e_pc = 0; e_a = 0; e_b = 0; e_c = 0; e_we = 0; e_re = 0;
      e_op = '0; e_mode = 0;
      if (run_en && ms == 2) e_ir = 1;
      if (run_en && ms == 3) begin
        case (ir[7:5])
          3'b000: begin e_pc = 1; e_a = !ir[0]; e_b = ir[0]; end
          3'b010: begin e_pc = 1; e_c = 1; e_op = ir[4:2]; e_mode = ir[1]; end
          3'b001: begin e_pc = 1; e_we = 1; end
          3'b011: begin e_pc = 1; e_re = 1; end
          3'b111: ;
          default: e_pc = 1;
        endcase
      end
      if (just_reset) tag = "R1";
      else if (en_fell) tag = "R11";
      else if (!run_en) tag = "R2";
      else if (ms == 4) tag = "R9";
      else if (ms != 3) tag = "R4";
      else case (ir[7:5])
        3'b000: tag = "R6";
        3'b010: tag = "R7";
        3'b001, 3'b011: tag = "R8";
        3'b111: tag = "R9";
        default: tag = "R10";
      endcase
      chk("R3 addr_sel", {31'd0, addr_sel}, {31'd0, run_en});
      chk("R5 ld_pc", {31'd0, ld_pc}, {31'd0, e_pc});
      chk(tag, {21'd0, ld_ir, ld_a, ld_b, ld_c, dm_we, dm_re, alu_op, alu_mode},
               {21'd0, e_ir, e_a, e_b, e_c, e_we, e_re, e_op, e_mode});
      s_ld_ir = ld_ir;
      s_ld_pc = ld_pc;
      just_reset = 0;
    end else begin
      s_ld_ir = 0;
      s_ld_pc = 0;
    end
  end

  // flag the cycle after run falls (R11)
  always @(negedge clk) begin
    en_fell = prev_en && !run_en && ms != 4;
    prev_en = run_en;
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);          // R2 idle with run low
    run_en = 1;                          // R4 start
    repeat (20) @(negedge clk);
    run_en = 0;                          // R11 abort mid program
    repeat (3) @(negedge clk);
    run_en = 1;                          // R11 restart at fetch
    for (int i = 0; i < 200 && ms != 4; i++) @(negedge clk);
    repeat (5) @(negedge clk);           // R9 stays halted
    run_en = 0;
    repeat (2) @(negedge clk);
    run_en = 1;
    repeat (4) @(negedge clk);
    rst = 1;                             // R1 reset leaves halt
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (15) @(negedge clk);
    finish_run();
  end

  initial begin
    #(20 * 5000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule